// File: doc/BRIEF.md
# Static 3½-Digit LCD Segment Driver

This block turns a latched decimal reading into direct-drive levels for a static (non-multiplexed) liquid crystal panel with three full digits, a leading half digit and a minus sign. Each full digit arrives as a BCD nibble and is decoded to seven segments. The half digit is a single bit that shows either nothing or a "1". One output serves both of the half digit's glass segments. A separate bit lights the minus sign, and an overrange flag clears the three low digits so that only the sign and the leading "1" stay visible.

LCD glass must never see a lasting DC voltage. The block therefore divides the oscillator clock by a parameterised ratio (default 800) to make a 50 % backplane square wave. Every segment pin follows that wave when the segment is dark and follows its inverse when the segment is lit. The backplane and all segment pins come from flops clocked on the same edge, so they switch together. A lamp-test input lights every segment, so the panel reads "-1888". In that mode the segment pins are held at a steady high level and no longer toggle with the backplane.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp` is a square wave that changes level every DIV_RATIO/2 clock cycles (400 with the default of 800) and is never held longer, so its period is DIV_RATIO cycles.
- R2: Outside lamp test, each segment pin equals `bp` when its segment is dark and equals the inverse of `bp` when it is lit. It changes on the same clock edge as `bp` and reflects the inputs sampled on that edge, one cycle after they are applied.
- R3: A digit code from 0 to 9 lights the standard pattern. Bit 0 of each 7-bit bus is segment a and bit 6 is segment g (a=0,b=1,c=2,d=3,e=4,f=5,g=6). The codes give 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F, so 6 includes segment a and 9 includes segment d.
- R4: A digit code from 10 to 15 leaves every segment of that digit dark. Neighbouring digits are not affected.
- R5: `seg_thou` is lit exactly when `thou_one` is 1.
- R6: `seg_minus` is lit exactly when `neg` is 1.
- R7: While `ovr` is 1, the units, tens and hundreds digits are dark whatever their codes. `seg_thou` and `seg_minus` still follow their inputs.
- R8: While `lamp_test` is 1, all 23 segment pins are held at a constant 1 for as long as the input stays high, including across `bp` transitions. This overrides the reading and the overrange flag. Normal phased drive resumes on the first edge after release.
- R9: While `rst_n` is 0, `bp` and every segment pin are 0. The backplane divider restarts, so the first `bp` change comes DIV_RATIO/2 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dig_units | input | 4 | BCD code of the units digit |
| dig_tens | input | 4 | BCD code of the tens digit |
| dig_hund | input | 4 | BCD code of the hundreds digit |
| thou_one | input | 1 | Leading half digit shows "1" |
| neg | input | 1 | Reading is negative |
| ovr | input | 1 | Overrange: blank the three low digits |
| lamp_test | input | 1 | Light every segment with a steady level |
| bp | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units segment pins, bit 0 = a to bit 6 = g |
| seg_tens | output | 7 | Tens segment pins, bit 0 = a to bit 6 = g |
| seg_hund | output | 7 | Hundreds segment pins, bit 0 = a to bit 6 = g |
| seg_thou | output | 1 | Shared pin for both segments of the half digit |
| seg_minus | output | 1 | Minus sign pin |

## Verification
The bench does not compare raw pin levels. It removes the backplane phase from each sample by XOR-ing the segment pins with `bp`. This exposes a driver that polarises the glass the wrong way (lit segments in phase) or one whose segment flop updates a cycle after the backplane flop, which would show a one-cycle glitch at every backplane edge. Lamp test is held across a full backplane transition: a design that keeps toggling lit segments in lamp mode, or that lets overrange blank digits in lamp mode, is caught there. Codes 10 to 15, and overrange together with a valid leading "1" and minus, target a decoder that shows junk instead of a blank, and a blanking rule that also clears the sign or half digit. The backplane interval is timed against 400 cycles both from reset and between edges, which catches an off-by-one divider.

// File: rtl/lcd_drv_pkg.sv
`timescale 1ns/1ps
package lcd_drv_pkg;

   localparam int BCD_W = 4;
   localparam int SEG_W = 7;

   typedef logic [SEG_W-1:0] seg7_t;   // bit0 = a ... bit6 = g

   // Lit-segment pattern for one decimal code; codes above 9 stay dark.
   function automatic seg7_t bcd_to_seg(input logic [BCD_W-1:0] code);
      seg7_t s;
      case (code)
         4'd0:    s = 7'b011_1111;
         4'd1:    s = 7'b000_0110;
         4'd2:    s = 7'b101_1011;
         4'd3:    s = 7'b100_1111;
         4'd4:    s = 7'b110_0110;
         4'd5:    s = 7'b110_1101;
         4'd6:    s = 7'b111_1101;
         4'd7:    s = 7'b000_0111;
         4'd8:    s = 7'b111_1111;
         4'd9:    s = 7'b110_1111;
         default: s = 7'b000_0000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
`timescale 1ns/1ps
module lcd_bp_gen #(
   parameter int HALF_CNT = 400
) (
   input  logic clk,
   input  logic rst_n,
   output logic bp,
   output logic bp_next
);
   localparam int CNT_W = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CNT - 1);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap    = (cnt == LAST);
   assign bp_next = wrap ? ~bp : bp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         bp  <= 1'b0;
      end else begin
         bp  <= bp_next;
         cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/lcd_digit_dec.sv
`timescale 1ns/1ps
module lcd_digit_dec
   import lcd_drv_pkg::*;
(
   input  logic [BCD_W-1:0] code,
   input  logic             blank,
   output seg7_t            lit
);
   always_comb begin
      lit = blank ? '0 : bcd_to_seg(code);
   end
endmodule

// File: rtl/lcd_seg_drive.sv
`timescale 1ns/1ps
module lcd_seg_drive #(
   parameter int N       = 23,
   parameter bit LAMP_DC = 1'b1   // 1: steady level in lamp test, 0: keep square wave
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lit,
   input  logic         lamp,
   input  logic         bp_next,
   output logic [N-1:0] pins
);
   logic [N-1:0] nxt;

   generate
      if (LAMP_DC) begin : g_lamp_dc
         always_comb nxt = lamp ? {N{1'b1}} : (lit ^ {N{bp_next}});
      end else begin : g_lamp_ac
         always_comb nxt = (lamp ? {N{1'b1}} : lit) ^ {N{bp_next}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pins <= '0;
      else        pins <= nxt;
   end
endmodule

// File: rtl/lcd_static_driver.sv
`timescale 1ns/1ps
module lcd_static_driver
   import lcd_drv_pkg::*;
#(
   parameter int DIV_RATIO = 800,
   parameter bit LAMP_DC   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] dig_units,
   input  logic [3:0] dig_tens,
   input  logic [3:0] dig_hund,
   input  logic       thou_one,
   input  logic       neg,
   input  logic       ovr,
   input  logic       lamp_test,
   output logic       bp,
   output logic [6:0] seg_units,
   output logic [6:0] seg_tens,
   output logic [6:0] seg_hund,
   output logic       seg_thou,
   output logic       seg_minus
);
   localparam int HALF    = DIV_RATIO / 2;
   localparam int NDIG    = 3;
   localparam int NPIN    = NDIG * SEG_W + 2;

   generate
      if (DIV_RATIO < 2 || (DIV_RATIO % 2) != 0) begin : g_bad_div
         $error("DIV_RATIO must be even and at least 2");
      end
   endgenerate

   logic              bp_next;
   logic [BCD_W-1:0]  codes [NDIG];
   seg7_t             lit   [NDIG];
   logic [NPIN-1:0]   lit_all;
   logic [NPIN-1:0]   pins;

   assign codes[0] = dig_units;
   assign codes[1] = dig_tens;
   assign codes[2] = dig_hund;

   lcd_bp_gen #(.HALF_CNT(HALF)) i_bp (
      .clk     (clk),
      .rst_n   (rst_n),
      .bp      (bp),
      .bp_next (bp_next)
   );

   generate
      for (genvar d = 0; d < NDIG; d++) begin : g_dig
         lcd_digit_dec i_dec (
            .code  (codes[d]),
            .blank (ovr),
            .lit   (lit[d])
         );
         assign lit_all[d*SEG_W +: SEG_W] = lit[d];
      end
   endgenerate

   assign lit_all[NDIG*SEG_W]     = thou_one;
   assign lit_all[NDIG*SEG_W + 1] = neg;

   lcd_seg_drive #(.N(NPIN), .LAMP_DC(LAMP_DC)) i_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .lit     (lit_all),
      .lamp    (lamp_test),
      .bp_next (bp_next),
      .pins    (pins)
   );

   assign seg_units = pins[0*SEG_W +: SEG_W];
   assign seg_tens  = pins[1*SEG_W +: SEG_W];
   assign seg_hund  = pins[2*SEG_W +: SEG_W];
   assign seg_thou  = pins[NDIG*SEG_W];
   assign seg_minus = pins[NDIG*SEG_W + 1];
endmodule

// File: rtl/lcd_static_driver_chk.sv
`timescale 1ns/1ps
module lcd_static_driver_chk #(
   parameter int HALF = 400
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] dig_units,
   input logic [3:0] dig_tens,
   input logic       thou_one,
   input logic       neg,
   input logic       ovr,
   input logic       lamp_test,
   input logic       bp,
   input logic [6:0] seg_units,
   input logic [6:0] seg_tens,
   input logic [6:0] seg_hund,
   input logic       seg_thou,
   input logic       seg_minus
);
   localparam int GAP_W = $clog2(HALF + 2) + 1;

   logic             bp_d;
   logic             armed;
   logic [GAP_W-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_d  <= 1'b0;
         armed <= 1'b0;
         gap   <= '0;
      end else begin
         bp_d  <= bp;
         armed <= 1'b1;
         if (bp != bp_d)                gap <= GAP_W'(1);
         else if (gap != GAP_W'(HALF + 1)) gap <= gap + 1'b1;
      end
   end

   // R1: bp changes exactly when HALF edges have passed since its last change
   p_bp_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bp != bp_d) == (gap == GAP_W'(HALF)));

   // R5 with R2: half digit pin follows its input in antiphase
   p_thou_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(lamp_test)) |-> (seg_thou == ($past(thou_one) ^ bp)));

   // R6 with R2: minus pin follows sign in antiphase
   p_minus_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(lamp_test)) |-> (seg_minus == ($past(neg) ^ bp)));

   // R7: overrange leaves the low digits in phase with the backplane
   p_ovr_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(lamp_test) && $past(ovr)) |->
      (seg_units == {7{bp}} && seg_tens == {7{bp}} && seg_hund == {7{bp}}));

   // R4: an out-of-range code leaves its digit dark
   p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(lamp_test) && ($past(dig_units) > 4'd9)) |->
      (seg_units == {7{bp}}));

   p_bad_tens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(lamp_test) && ($past(dig_tens) > 4'd9)) |->
      (seg_tens == {7{bp}}));

   // R8: lamp test holds every pin high
   p_lamp_dc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(lamp_test)) |->
      (seg_units == 7'h7F && seg_tens == 7'h7F && seg_hund == 7'h7F
       && seg_thou && seg_minus));
endmodule

bind lcd_static_driver lcd_static_driver_chk #(.HALF(DIV_RATIO / 2)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dig_units (dig_units),
   .dig_tens  (dig_tens),
   .thou_one  (thou_one),
   .neg       (neg),
   .ovr       (ovr),
   .lamp_test (lamp_test),
   .bp        (bp),
   .seg_units (seg_units),
   .seg_tens  (seg_tens),
   .seg_hund  (seg_hund),
   .seg_thou  (seg_thou),
   .seg_minus (seg_minus)
);

// File: tb/test_lcd_static_driver.sv
`timescale 1ns/1ps
module test_lcd_static_driver;
   localparam int HALF_EXP = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] dig_units = 4'd0, dig_tens = 4'd0, dig_hund = 4'd0;
   logic       thou_one = 1'b0, neg = 1'b0, ovr = 1'b0, lamp_test = 1'b0;
   logic       bp;
   logic [6:0] seg_units, seg_tens, seg_hund;
   logic       seg_thou, seg_minus;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   lcd_static_driver i_lcd_static_driver (
      .clk(clk), .rst_n(rst_n),
      .dig_units(dig_units), .dig_tens(dig_tens), .dig_hund(dig_hund),
      .thou_one(thou_one), .neg(neg), .ovr(ovr), .lamp_test(lamp_test),
      .bp(bp), .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
      .seg_thou(seg_thou), .seg_minus(seg_minus)
   );

   // Expected lit pattern, bit0 = a .. bit6 = g (R3/R4)
   function automatic logic [6:0] pat(input logic [3:0] c);
      logic [6:0] p;
      p = 7'h00;
      if (c == 4'd0) p = 7'h3F;
      if (c == 4'd1) p = 7'h06;
      if (c == 4'd2) p = 7'h5B;
      if (c == 4'd3) p = 7'h4F;
      if (c == 4'd4) p = 7'h66;
      if (c == 4'd5) p = 7'h6D;
      if (c == 4'd6) p = 7'h7D;
      if (c == 4'd7) p = 7'h07;
      if (c == 4'd8) p = 7'h7F;
      if (c == 4'd9) p = 7'h6F;
      return p;
   endfunction

   task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // apply inputs at negedge, sample after one posedge at next negedge
   task automatic apply(input logic [3:0] u, input logic [3:0] t, input logic [3:0] h,
                        input logic th, input logic ng, input logic ov, input logic lt);
      @(negedge clk);
      dig_units = u; dig_tens = t; dig_hund = h;
      thou_one = th; neg = ng; ovr = ov; lamp_test = lt;
      @(negedge clk);
   endtask

   function automatic logic [22:0] lit_view();
      return {seg_minus, seg_thou, seg_hund, seg_tens, seg_units} ^ {23{bp}};
   endfunction

   task automatic show(input string req, input logic [3:0] u, input logic [3:0] t,
                       input logic [3:0] h, input logic th, input logic ng, input logic ov);
      logic [6:0] eu, et, eh;
      apply(u, t, h, th, ng, ov, 1'b0);
      eu = ov ? 7'h00 : pat(u);
      et = ov ? 7'h00 : pat(t);
      eh = ov ? 7'h00 : pat(h);
      check(req, lit_view(), {ng, th, eh, et, eu});
   endtask

   task automatic t_reset_r9();
      @(negedge clk);
      check("R9 reset pins", {seg_minus, seg_thou, seg_hund, seg_tens, seg_units, bp}[22:0], 23'h0);
      n_chk++;
      if (bp !== 1'b0) begin n_fail++; $display("FAIL R9: bp actual %b expected 0", bp); end
   endtask

   task automatic t_period_r1();
      int cnt;
      // after reset release: first change after HALF cycles (R9, R1)
      cnt = 0;
      while (bp === 1'b0 && cnt < 2000) begin @(negedge clk); cnt++; end
      n_chk++;
      if (cnt != HALF_EXP) begin n_fail++; $display("FAIL R9: first bp edge after %0d expected %0d", cnt, HALF_EXP); end
      for (int k = 0; k < 2; k++) begin
         logic lvl;
         lvl = bp; cnt = 0;
         while (bp === lvl && cnt < 2000) begin @(negedge clk); cnt++; end
         n_chk++;
         if (cnt != HALF_EXP) begin n_fail++; $display("FAIL R1: bp interval %0d expected %0d", cnt, HALF_EXP); end
      end
   endtask

   task automatic t_decode_r3();
      for (int d = 0; d < 10; d++)
         show("R3 decode", 4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10), 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_phase_r2();
      // R2: raw pins vs bp on both backplane levels; lit -> ~bp, dark -> bp
      for (int k = 0; k < 2; k++) begin
         logic lvl;
         apply(4'd1, 4'd7, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0);
         lvl = bp;
         check("R2 raw pins", {seg_minus, seg_thou, seg_hund, seg_tens, seg_units},
               {lvl, ~lvl, pat(4'd4) ^ {7{lvl}}, pat(4'd7) ^ {7{lvl}}, pat(4'd1) ^ {7{lvl}}});
         while (bp === lvl) @(negedge clk);
      end
      // R2: one-cycle latency
      @(negedge clk);
      dig_units = 4'd8;
      @(negedge clk);
      check("R2 latency", {16'h0, lit_view()[6:0]}, {16'h0, 7'h7F});
   endtask

   task automatic t_bad_code_r4();
      show("R4 code 10/15", 4'hA, 4'hF, 4'd3, 1'b0, 1'b0, 1'b0);
      show("R4 code 12", 4'd2, 4'd5, 4'hC, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_thou_minus_r5_r6();
      show("R5 thou on", 4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0);
      show("R6 minus on", 4'd9, 4'd9, 4'd9, 1'b0, 1'b1, 1'b0);
      show("R5 R6 both", 4'd2, 4'd4, 4'd6, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_ovr_r7();
      show("R7 overrange", 4'd5, 4'd5, 4'd5, 1'b1, 1'b1, 1'b1);
      show("R7 overrange pos", 4'd8, 4'd8, 4'd8, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_lamp_r8();
      int bad;
      logic lvl;
      apply(4'd3, 4'hB, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      lvl = bp; bad = 0;
      // hold across at least one bp transition
      for (int k = 0; k < HALF_EXP + 20; k++) begin
         if ({seg_minus, seg_thou, seg_hund, seg_tens, seg_units} !== 23'h7FFFFF) bad++;
         @(negedge clk);
      end
      n_chk++;
      if (bp === lvl) begin n_fail++; $display("FAIL R8: bp did not move during lamp window, actual %b expected %b", bp, ~lvl); end
      check("R8 lamp steady", 23'(bad), 23'h0);
      show("R8 release", 4'd3, 4'd6, 4'd9, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(150000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      t_reset_r9();
      @(negedge clk);
      rst_n = 1'b1;
      t_period_r1();
      t_decode_r3();
      t_phase_r2();
      t_bad_code_r4();
      t_thou_minus_r5_r6();
      t_ovr_r7();
      t_lamp_r8();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule